// File: doc/BRIEF.md
# Slot-Arbitrated Hardware Lock Bank

This block holds a small bank of single-bit hardware locks shared by a group of cores. A slot counter rotates through the cores, one per clock, and only the core that owns the current slot may act on the bank. Because no two cores can ever touch the locks in the same cycle, every operation is atomic with no further handshaking. A test-and-set, for example, takes a single slot.

A core posts one request. The request names one of four operations and a lock number. If the core's slot is not current, the request is kept in a per-core holding register until the slot arrives. One cycle after the serving slot, the core sees a one-cycle response strobe. With the strobe comes a result bit, which is the value the addressed lock held before the operation. The complete lock vector is also driven out in parallel, so that edge-sensing logic in every core can watch for lock transitions.

Top module: `lock_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all locks clear to 0, all held requests are dropped (`busy` all 0), and no response strobe is raised in the following cycle.
- R2: The service slot is 0 in the first cycle after reset, advances by one every clock and wraps from 15 to 0. Core k is served only in a cycle whose slot is k, so a request core 0 posts in slot 1 is answered 16 cycles later.
- R3: Operation code 2'b00 (set) forces the addressed lock to 1 and returns its previous value in `rsp_bit`.
- R4: Operation code 2'b01 (clear) forces the addressed lock to 0 and returns its previous value.
- R5: Operation code 2'b10 (get) returns the addressed lock's current value and changes no lock.
- R6: Operation code 2'b11 (toggle) inverts the addressed lock and returns its value from before the toggle.
- R7: A request posted in a cycle whose slot is not the core's own is held, with `busy[k]` high, until the core's slot. The response then appears ((k - slot) mod 16) + 1 cycles after the request cycle.
- R8: A request posted during the core's own slot is served in that same cycle, and its response appears in the next cycle.
- R9: A request pulse from a core whose `busy` bit is high is ignored. It changes no lock and produces no response.
- R10: `lock_state` shows every lock in parallel, with bit i being lock i. It reflects an operation's effect in the cycle in which that operation's response appears.
- R11: `rsp_valid` is one-hot or zero, high for one cycle and only for the served core. When two cores set the same free lock together, the core whose slot comes first receives 0 and the other receives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 16 | One-cycle request pulse, one bit per core |
| req_op | input | 32 | Operation code per core; core k uses bits [2k+1:2k] |
| req_id | input | 64 | Lock number per core; core k uses bits [4k+3:4k] |
| busy | output | 16 | Core k has a request held and awaiting its slot |
| rsp_valid | output | 16 | Response strobe per core, one cycle |
| rsp_bit | output | 1 | Previous value of the lock named by the response's request |
| lock_state | output | 16 | Current value of every lock |

## Verification
A vector table runs a sequence of operations from many different cores on a few shared locks. This exposes the result-bit semantics of each operation and mixes their effects, so a wrong operation decode or a wrong old-value capture produces a mismatch against the running lock model. Because the vectors start at arbitrary slot positions, each response latency checks the slot-wait formula. Directed cases isolate particular behaviours:
- a request made in the core's own slot, which separates the bypass path from the held path;
- a request one slot past the core's own, which forces the full wrap;
- a second pulse while a request is already held, which must be dropped;
- two cores racing to set one lock, which shows slot order decides ownership;
- reset issued with locks set and a request held.

// File: rtl/lock_bank_pkg.sv
// Shared definitions for the lock bank.
// Assumes: operation codes are two bits wide and are fixed by the port contract.
package lock_bank_pkg;

    typedef enum logic [1:0] {
        OP_SET = 2'b00,
        OP_CLR = 2'b01,
        OP_GET = 2'b10,
        OP_TOG = 2'b11
    } lock_op_e;

endpackage

// File: rtl/lock_slot_rotor.sv
// Rotating service-slot counter: names the one core allowed to touch the bank.
// Assumes: NUM_CORES >= 2; slot 0 is current in the first cycle after reset.
module lock_slot_rotor #(
    parameter int NUM_CORES = 16,
    localparam int SLOT_W   = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CORES - 1);

    // Advance one slot per clock, wrapping after the last core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == LAST_SLOT) begin
            slot <= '0;
        end else begin
            slot <= slot + SLOT_W'(1);
        end
    end

    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (slot == (($past(slot) == LAST_SLOT) ? '0 : $past(slot) + SLOT_W'(1))));

    p_slot_reset_r2: assert property (@(posedge clk)
        !rst_n |=> (slot == '0));

endmodule

// File: rtl/lock_req_hold.sv
// Per-core request holder: keeps a request posted outside the core's slot
// and presents either the held request or the live one to the arbiter.
// Assumes: a core pulses req_valid for one cycle; pulses while pending are dropped.
module lock_req_hold
    import lock_bank_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [ID_W-1:0] req_id,
    input  logic            grant,
    output logic            pending,
    output logic            eff_valid,
    output logic [1:0]      eff_op,
    output logic [ID_W-1:0] eff_id
);

    lock_op_e        held_op;
    logic [ID_W-1:0] held_id;

    // Capture a fresh request when idle and not served now; release on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            held_op <= OP_GET;
            held_id <= '0;
        end else if (grant) begin
            pending <= 1'b0;
        end else if (req_valid && !pending) begin
            pending <= 1'b1;
            held_op <= lock_op_e'(req_op);
            held_id <= req_id;
        end
    end

    // Held request takes priority; otherwise the live one may use this slot.
    always_comb begin
        eff_valid = pending | req_valid;
        eff_op    = pending ? held_op : req_op;
        eff_id    = pending ? held_id : req_id;
    end

    p_hold_until_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !grant) |=> pending);

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !grant) |=> ($stable(held_op) && $stable(held_id)));

    p_release_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !pending);

    p_reset_drop_r1: assert property (@(posedge clk)
        !rst_n |=> !pending);

endmodule

// File: rtl/lock_grant_mux.sv
// Slot grant and request select: the core named by the slot is granted if it
// has an effective request, and its operation and lock number are forwarded.
// Assumes: the slot value is always below NUM_CORES.
module lock_grant_mux #(
    parameter int NUM_CORES = 16,
    parameter int ID_W      = 4,
    localparam int SLOT_W   = $clog2(NUM_CORES)
) (
    input  logic [SLOT_W-1:0]         slot,
    input  logic [NUM_CORES-1:0]      eff_valid,
    input  logic [NUM_CORES*2-1:0]    eff_op,
    input  logic [NUM_CORES*ID_W-1:0] eff_id,
    output logic [NUM_CORES-1:0]      grant,
    output logic                      do_op,
    output logic [1:0]                sel_op,
    output logic [ID_W-1:0]           sel_id
);

    // Decode the slot owner and pick its request fields.
    always_comb begin
        grant             = '0;
        grant[int'(slot)] = eff_valid[int'(slot)];
        do_op             = eff_valid[int'(slot)];
        sel_op            = eff_op[int'(slot)*2 +: 2];
        sel_id            = eff_id[int'(slot)*ID_W +: ID_W];
    end

endmodule

// File: rtl/lock_store.sv
// Lock storage and operation engine: applies at most one operation per cycle
// and captures the addressed lock's prior value as the result bit.
// Assumes: do_op is asserted for at most one core's request per cycle.
module lock_store
    import lock_bank_pkg::*;
#(
    parameter int NUM_LOCKS = 16,
    localparam int ID_W     = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_op,
    input  logic [1:0]           op,
    input  logic [ID_W-1:0]      id,
    output logic [NUM_LOCKS-1:0] locks,
    output logic                 old_bit
);

    lock_op_e op_e;
    assign op_e = lock_op_e'(op);

    // Apply the granted operation and record the addressed lock's old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locks   <= '0;
            old_bit <= 1'b0;
        end else if (do_op) begin
            old_bit <= locks[id];
            case (op_e)
                OP_SET:  locks[id] <= 1'b1;
                OP_CLR:  locks[id] <= 1'b0;
                OP_TOG:  locks[id] <= ~locks[id];
                default: locks[id] <= locks[id];
            endcase
        end
    end

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op_e == OP_SET) |=> (locks[$past(id)] == 1'b1));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op_e == OP_CLR) |=> (locks[$past(id)] == 1'b0));

    p_get_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op_e == OP_GET) |=> $stable(locks));

    p_tog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_op && op_e == OP_TOG) |=> (locks[$past(id)] != $past(locks[id])));

    p_old_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_op |=> (old_bit == $past(locks[id])));

    p_only_addressed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_op |=> (((locks ^ $past(locks)) & ~(NUM_LOCKS'(1) << $past(id))) == '0));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !do_op |=> $stable(locks));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (locks == '0));

endmodule

// File: rtl/lock_bank.sv
// Slot-arbitrated hardware lock bank: NUM_CORES cores share NUM_LOCKS
// single-bit locks; each core may act only in its own rotating slot, which
// makes set/clear/get/toggle atomic. Results arrive one cycle after the slot.
// Assumes: NUM_CORES is a power of two (slot field fully used).
module lock_bank
    import lock_bank_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int NUM_LOCKS = 16,
    localparam int ID_W     = $clog2(NUM_LOCKS),
    localparam int SLOT_W   = $clog2(NUM_CORES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES-1:0]      req_valid,
    input  logic [NUM_CORES*2-1:0]    req_op,
    input  logic [NUM_CORES*ID_W-1:0] req_id,
    output logic [NUM_CORES-1:0]      busy,
    output logic [NUM_CORES-1:0]      rsp_valid,
    output logic                      rsp_bit,
    output logic [NUM_LOCKS-1:0]      lock_state
);

    logic [SLOT_W-1:0]         slot;
    logic [NUM_CORES-1:0]      grant;
    logic [NUM_CORES-1:0]      eff_valid;
    logic [NUM_CORES*2-1:0]    eff_op;
    logic [NUM_CORES*ID_W-1:0] eff_id;
    logic                      do_op;
    logic [1:0]                sel_op;
    logic [ID_W-1:0]           sel_id;

    lock_slot_rotor #(.NUM_CORES(NUM_CORES)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lock_req_hold #(.ID_W(ID_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[c]),
            .req_op    (req_op[c*2 +: 2]),
            .req_id    (req_id[c*ID_W +: ID_W]),
            .grant     (grant[c]),
            .pending   (busy[c]),
            .eff_valid (eff_valid[c]),
            .eff_op    (eff_op[c*2 +: 2]),
            .eff_id    (eff_id[c*ID_W +: ID_W])
        );
    end

    lock_grant_mux #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_mux (
        .slot      (slot),
        .eff_valid (eff_valid),
        .eff_op    (eff_op),
        .eff_id    (eff_id),
        .grant     (grant),
        .do_op     (do_op),
        .sel_op    (sel_op),
        .sel_id    (sel_id)
    );

    lock_store #(.NUM_LOCKS(NUM_LOCKS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_op   (do_op),
        .op      (sel_op),
        .id      (sel_id),
        .locks   (lock_state),
        .old_bit (rsp_bit)
    );

    // Strobe the served core's response one cycle after its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
        end else begin
            rsp_valid <= grant;
        end
    end

    p_rsp_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    p_rsp_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> grant[int'(slot)]);

    p_rsp_follows_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (rsp_valid == (NUM_CORES'(1) << $past(slot))));

    p_no_rsp_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (rsp_valid == '0));

endmodule

// File: tb/lock_bank_test.sv
module lock_bank_test;

    localparam int N  = 16;
    localparam int L  = 16;
    localparam int IW = 4;

    // Vector fields: [11:8] core, [7:6] op, [5:2] lock, [1] result, [0] lock after
    localparam logic [11:0] VEC [12] = '{
        {4'd3,  2'b10, 4'd5,  1'b0, 1'b0},
        {4'd3,  2'b00, 4'd5,  1'b0, 1'b1},
        {4'd7,  2'b00, 4'd5,  1'b1, 1'b1},
        {4'd7,  2'b10, 4'd5,  1'b1, 1'b1},
        {4'd0,  2'b11, 4'd5,  1'b1, 1'b0},
        {4'd15, 2'b11, 4'd5,  1'b0, 1'b1},
        {4'd9,  2'b01, 4'd5,  1'b1, 1'b0},
        {4'd9,  2'b01, 4'd5,  1'b0, 1'b0},
        {4'd1,  2'b00, 4'd0,  1'b0, 1'b1},
        {4'd2,  2'b00, 4'd15, 1'b0, 1'b1},
        {4'd12, 2'b10, 4'd15, 1'b1, 1'b1},
        {4'd4,  2'b01, 4'd0,  1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*2-1:0]  req_op = '0;
    logic [N*IW-1:0] req_id = '0;
    logic [N-1:0]    busy;
    logic [N-1:0]    rsp_valid;
    logic            rsp_bit;
    logic [L-1:0]    lock_state;

    int errors = 0;
    int checks = 0;
    int wd = 0;
    logic [3:0]   bslot;
    logic [L-1:0] model = '0;

    always #5 clk = ~clk;

    lock_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_bit(rsp_bit), .lock_state(lock_state)
    );

    // Slot the requirements predict: 0 after reset, +1 per clock, wraps at 16 (R2).
    always @(posedge clk) begin
        if (!rst_n) bslot <= 4'd0;
        else        bslot <= bslot + 4'd1;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", wd);
            summary();
            $finish;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(int core, logic [1:0] op, logic [3:0] id);
        req_valid[core]         = 1'b1;
        req_op[core*2 +: 2]     = op;
        req_id[core*IW +: IW]   = id;
    endtask

    task automatic undrive(int core);
        req_valid[core]         = 1'b0;
        req_op[core*2 +: 2]     = 2'b00;
        req_id[core*IW +: IW]   = 4'd0;
    endtask

    task automatic wait_slot(int s);
        while (int'(bslot) != s) @(negedge clk);
    endtask

    // Issue one request at a negedge and check latency, result and strobe.
    task automatic run_op(int core, logic [1:0] op, logic [3:0] id,
                          logic exp_rsp, string tag);
        int exp_lat;
        int k;
        bit seen;
        exp_lat = ((core - int'(bslot)) & 15) + 1;
        drive(core, op, id);
        k = 0;
        seen = 0;
        while (!seen && k < 40) begin
            @(negedge clk);
            k++;
            undrive(core);
            if (k == 1 && exp_lat > 1) check("R7 busy while held", 64'(busy[core]), 64'd1);
            if (rsp_valid != '0) seen = 1;
        end
        check("R7 response latency", 64'(k), 64'(exp_lat));
        check("R11 strobe to requester only", 64'(rsp_valid), 64'(N'(1) << core));
        check(tag, 64'(rsp_bit), 64'(exp_rsp));
    endtask

    initial begin
        string tags [4];
        tags[0] = "R3 set result";
        tags[1] = "R4 clear result";
        tags[2] = "R5 get result";
        tags[3] = "R6 toggle result";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check("R1 locks after reset", 64'(lock_state), 64'd0);
        check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        check("R1 busy after reset", 64'(busy), 64'd0);

        // Vector table walk (R3..R7, R10, R11)
        for (int v = 0; v < 12; v++) begin
            int c;
            logic [1:0] op;
            logic [3:0] id;
            c  = int'(VEC[v][11:8]);
            op = VEC[v][7:6];
            id = VEC[v][5:2];
            run_op(c, op, id, VEC[v][1], tags[op]);
            model[id] = VEC[v][0];
            check("R10 lock vector", 64'(lock_state), 64'(model));
            @(negedge clk);
        end

        // R8: request in the core's own slot is served at once
        wait_slot(6);
        run_op(6, 2'b10, 4'd15, 1'b1, "R8 own-slot get result");
        check("R5 get leaves locks", 64'(lock_state), 64'(model));

        // R2: core 0 asking in slot 1 waits for the full wrap (16 cycles)
        wait_slot(1);
        run_op(0, 2'b11, 4'd3, 1'b0, "R2 wrap toggle result");
        model[3] = 1'b1;
        check("R6 toggle applied", 64'(lock_state), 64'(model));

        // R9: a second pulse while busy is dropped
        begin
            int rsp_count;
            wait_slot(2);
            drive(10, 2'b00, 4'd7);
            @(negedge clk);
            undrive(10);
            check("R9 busy before second pulse", 64'(busy[10]), 64'd1);
            drive(10, 2'b00, 4'd8);
            @(negedge clk);
            undrive(10);
            rsp_count = 0;
            for (int i = 0; i < 40; i++) begin
                if (rsp_valid[10]) rsp_count++;
                @(negedge clk);
            end
            model[7] = 1'b1;
            check("R9 one response only", 64'(rsp_count), 64'd1);
            check("R9 second request had no effect", 64'(lock_state), 64'(model));
            check("R9 not busy afterwards", 64'(busy[10]), 64'd0);
        end

        // R11: two cores race to set lock 9; slot order decides
        begin
            int lat5, lat6;
            logic b5, b6;
            lat5 = 0; lat6 = 0; b5 = 1'bx; b6 = 1'bx;
            wait_slot(0);
            drive(5, 2'b00, 4'd9);
            drive(6, 2'b00, 4'd9);
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                undrive(5);
                undrive(6);
                if (rsp_valid[5]) begin lat5 = k; b5 = rsp_bit; end
                if (rsp_valid[6]) begin lat6 = k; b6 = rsp_bit; end
            end
            model[9] = 1'b1;
            check("R11 first core latency", 64'(lat5), 64'd6);
            check("R11 second core latency", 64'(lat6), 64'd7);
            check("R11 first core wins", 64'(b5), 64'd0);
            check("R11 second core sees taken", 64'(b6), 64'd1);
            check("R10 lock vector after race", 64'(lock_state), 64'(model));
        end

        // R1: reset with locks set and a request held
        wait_slot(3);
        drive(12, 2'b00, 4'd1);
        @(negedge clk);
        undrive(12);
        check("R7 held before reset", 64'(busy[12]), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 locks cleared by reset", 64'(lock_state), 64'd0);
        check("R1 held request dropped", 64'(busy), 64'd0);
        rst_n = 1'b1;
        begin
            int rsp_seen;
            rsp_seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (rsp_valid != '0) rsp_seen++;
            end
            check("R1 no response after reset", 64'(rsp_seen), 64'd0);
            check("R1 locks stay clear", 64'(lock_state), 64'd0);
        end

        summary();
        $finish;
    end

endmodule